// File: doc/BRIEF.md
# PCI Bus Parity Generator and Checker

This block produces and checks the even parity bit of a conventional PCI bus for a device that can be either bus master or target. It folds the 32 address/data lines and the four command/byte-enable lines into one parity bit. The result is presented on the PAR line one clock after the bus carried those bits. The block turns the PAR output driver on only for the phases that its role and the transfer direction give it.

When the device is the receiving agent, the block compares the PAR value seen on the bus with the parity of the bits latched one clock earlier. A bad data phase is reported by pulling the parity-error line low in the second clock after that phase. A bad address phase seen as target is reported on the open-drain system-error line. Two sticky status flags record these events until configuration software writes a one to clear them. Arbitration, address decode and data movement live elsewhere. This block only watches the bus lines and the role and direction flags that the bus engine supplies.

Top module: `pci_parity_unit`

## Requirements
- R1: Whenever `par_oe` is high, `par_out` equals the XOR of all bits of `ad` and `cbe_n` sampled on the previous rising edge, so the ones across AD, C/BE# and PAR count even.
- R2: As master (`is_master`=1), `par_oe` is high in the clock after an address phase. An address phase is a rising edge with `frame_n` low where `frame_n` was high on the edge before.
- R3: As master on a write (`is_write`=1), `par_oe` is high in the clock after every edge with `irdy_n` low. This holds PAR through wait states and for one clock after the completing edge, and drops it the clock after `irdy_n` returns high.
- R4: As target, `par_oe` is high in the clock after an edge with `trdy_n` low on a read (`is_write`=0). It is never high for a target on a write, and never high in the clock after a target address phase.
- R5: A data phase completes on an edge where `irdy_n` and `trdy_n` are both low. If the block is the receiver (master read or target write) and `par_in` on the next edge differs from the parity of that phase, `perr_n` goes low for one clock starting after that next edge, provided `perr_en` is 1.
- R6: A data parity error in a phase marked by `special_cycle`=1 never pulls `perr_n` low.
- R7: As target only, an address phase whose `par_in` on the next edge is wrong raises `serr_pull` (drive SERR# low) for one clock and sets `sts_sig_serr` (status bit 14), provided `serr_en` is 1. A master never raises it.
- R8: `sts_det_perr` (status bit 15) is set by any detected address or data parity error, whatever `perr_en`, `serr_en` or `special_cycle` are.
- R9: Both status flags are sticky. `status_clr[1]` clears bit 15 and `status_clr[0]` clears bit 14 on the next edge. A new error on that same edge wins over the clear.
- R10: On reset, `par_oe`=0, `perr_n`=1, `serr_pull`=0 and both status flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ad | input | 32 | Address/data lines as seen on the bus |
| cbe_n | input | 4 | Command/byte-enable lines as seen on the bus |
| frame_n | input | 1 | FRAME#, active low |
| irdy_n | input | 1 | IRDY#, active low |
| trdy_n | input | 1 | TRDY#, active low |
| par_in | input | 1 | PAR as seen on the bus |
| is_master | input | 1 | 1 when this device owns the current transaction |
| is_write | input | 1 | 1 when data flows from master to target |
| special_cycle | input | 1 | Current transaction is a Special Cycle |
| perr_en | input | 1 | Command-register enable for parity-error reporting |
| serr_en | input | 1 | Command-register enable for system-error reporting |
| status_clr | input | 2 | Write-one-to-clear strobes: [1] bit 15, [0] bit 14 |
| par_out | output | 1 | Generated PAR value |
| par_oe | output | 1 | Output enable for the PAR driver |
| perr_n | output | 1 | PERR#, active low |
| serr_pull | output | 1 | 1 pulls the open-drain SERR# line low |
| sts_det_perr | output | 1 | Status bit 15: parity error detected |
| sts_sig_serr | output | 1 | Status bit 14: system error signalled |

## Verification
The assertions assume the bus engine keeps `is_master`, `is_write` and `special_cycle` steady for the whole transaction, including the clock after the last data phase. They also assume `par_in` always carries the parity for the bits of the edge before. The bench plays the other agent. It sets the role flags during an idle clock ahead of each transaction and changes them only after the trailing clock. It computes every `par_in` from the bits it drove one clock earlier and flips it only on purpose to inject an error. Every transaction opens with an idle clock, so `frame_n` is high before each address phase.

// File: rtl/pci_par_pkg.sv
// Package: shared widths and the status flag type of the PCI parity unit.
// Assumes a 32-bit bus with one byte-enable line per byte lane.
package pci_par_pkg;
    parameter int AD_W  = 32;
    parameter int CBE_W = 4;

    typedef struct packed {
        logic det_perr;   // status bit 15
        logic sig_serr;   // status bit 14
    } par_sts_t;
endpackage

// File: rtl/pci_par_tree.sv
// Parity tree: folds AD and C/BE# into one even-parity bit.
// Each byte lane and its enable line form one partial sum; the lane sums
// are then combined. Assumes AD_W is a multiple of CBE_W.
module pci_par_tree #(
    parameter int AD_W  = pci_par_pkg::AD_W,
    parameter int CBE_W = pci_par_pkg::CBE_W
) (
    input  logic [AD_W-1:0]  ad,
    input  logic [CBE_W-1:0] cbe_n,
    output logic             par
);
    localparam int LANE_W = AD_W / CBE_W;

    logic [CBE_W-1:0] lane_par;

    // Per-lane partial parity over the lane's data bits and its enable line.
    for (genvar i = 0; i < CBE_W; i++) begin : g_lane
        assign lane_par[i] = ^{ad[i*LANE_W +: LANE_W], cbe_n[i]};
    end

    // Combine the lane sums.
    assign par = ^lane_par;
endmodule

// File: rtl/pci_par_front.sv
// Front end: registers the bus parity one clock and recognises bus phases.
// Assumes the bus is idle (FRAME# high) for at least one clock before each
// address phase.
module pci_par_front #(
    parameter int AD_W  = pci_par_pkg::AD_W,
    parameter int CBE_W = pci_par_pkg::CBE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AD_W-1:0]  ad,
    input  logic [CBE_W-1:0] cbe_n,
    input  logic             frame_n,
    input  logic             irdy_n,
    input  logic             trdy_n,
    output logic             addr_phase,
    output logic             data_done,
    output logic             par_prev
);
    logic par_now;
    logic frame_q;

    pci_par_tree #(.AD_W(AD_W), .CBE_W(CBE_W)) u_tree (
        .ad    (ad),
        .cbe_n (cbe_n),
        .par   (par_now)
    );

    // Hold last clock's parity and FRAME# level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_prev <= 1'b0;
            frame_q  <= 1'b1;
        end else begin
            par_prev <= par_now;
            frame_q  <= frame_n;
        end
    end

    // Address phase: first clock of FRAME# low; completion: both ready lines low.
    assign addr_phase = !frame_n && frame_q;
    assign data_done  = !irdy_n && !trdy_n;
endmodule

// File: rtl/pci_par_drive.sv
// PAR driver: decides in which clocks this device owns the PAR line.
// Assumes is_master and is_write stay steady through a transaction.
module pci_par_drive (
    input  logic clk,
    input  logic rst_n,
    input  logic addr_phase,
    input  logic irdy_n,
    input  logic trdy_n,
    input  logic is_master,
    input  logic is_write,
    input  logic par_prev,
    output logic par_out,
    output logic par_oe
);
    logic oe_q;

    // Enable PAR one clock after a phase whose bits this device drove.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q <= 1'b0;
        end else if (is_master) begin
            oe_q <= addr_phase || (is_write && !irdy_n);
        end else begin
            oe_q <= !is_write && !trdy_n;
        end
    end

    assign par_oe  = oe_q;
    assign par_out = par_prev;

    // A target receiving write data never drives PAR.
    assert_target_write_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!is_master) && $past(is_write)) |-> !par_oe);

    // A master reading never drives PAR for data.
    assert_master_read_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(is_master) && $past(!is_write) && $past(!addr_phase)) |-> !par_oe);
endmodule

// File: rtl/pci_par_check.sv
// Parity checker: compares received PAR with last clock's bits, reports
// data errors on PERR# and target address errors on SERR#, and keeps
// the sticky status flags. Assumes par_in carries the other agent's parity
// for the previous clock.
module pci_par_check
    import pci_par_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       addr_phase,
    input  logic       data_done,
    input  logic       is_master,
    input  logic       is_write,
    input  logic       special_cycle,
    input  logic       par_prev,
    input  logic       par_in,
    input  logic       perr_en,
    input  logic       serr_en,
    input  logic [1:0] status_clr,
    output logic       perr_n,
    output logic       serr_pull,
    output par_sts_t   sts
);
    logic addr_q;
    logic dchk_q;
    logic spec_q;
    logic perr_q;
    logic serr_q;
    logic mismatch;
    logic aerr;
    logic derr;

    // Mark which phases of last clock this device must check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= 1'b0;
            dchk_q <= 1'b0;
            spec_q <= 1'b0;
        end else begin
            addr_q <= addr_phase && !is_master;
            dchk_q <= data_done && (is_master ^ is_write);
            spec_q <= special_cycle;
        end
    end

    // Compare received PAR against last clock's computed parity.
    assign mismatch = par_in ^ par_prev;
    assign aerr     = addr_q && mismatch;
    assign derr     = dchk_q && mismatch;

    // Report lines: one clock after the check, i.e. two after the phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            perr_q <= 1'b0;
            serr_q <= 1'b0;
        end else begin
            perr_q <= derr && perr_en && !spec_q;
            serr_q <= aerr && serr_en;
        end
    end

    // Sticky status flags; a new error outranks a same-clock clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts <= '0;
        end else begin
            if (aerr || derr)       sts.det_perr <= 1'b1;
            else if (status_clr[1]) sts.det_perr <= 1'b0;
            if (aerr && serr_en)    sts.sig_serr <= 1'b1;
            else if (status_clr[0]) sts.sig_serr <= 1'b0;
        end
    end

    assign perr_n    = !perr_q;
    assign serr_pull = serr_q;

    // PERR# only when reporting was enabled.
    assert_perr_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_n |-> $past(perr_en));

    // Never PERR# for a Special Cycle data phase.
    assert_perr_no_special_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_n |-> !$past(special_cycle, 2));

    // SERR# always leaves bit 14 set.
    assert_serr_sets_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
        serr_pull |-> (sts.sig_serr && $past(serr_en)));

    // Any report implies bit 15.
    assert_report_sets_detect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!perr_n || serr_pull) |-> sts.det_perr);

    // Bit 15 stays set unless cleared.
    assert_detect_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sts.det_perr) && !$past(status_clr[1])) |-> sts.det_perr);
endmodule

// File: rtl/pci_parity_unit.sv
// Top: PCI parity generation and checking for a master/target device.
// Assumes the bus engine supplies steady role/direction flags per transaction
// and the command-register enables; drives only PAR, PERR# and SERR# controls.
module pci_parity_unit
    import pci_par_pkg::*;
#(
    parameter int AD_W  = pci_par_pkg::AD_W,
    parameter int CBE_W = pci_par_pkg::CBE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AD_W-1:0]  ad,
    input  logic [CBE_W-1:0] cbe_n,
    input  logic             frame_n,
    input  logic             irdy_n,
    input  logic             trdy_n,
    input  logic             par_in,
    input  logic             is_master,
    input  logic             is_write,
    input  logic             special_cycle,
    input  logic             perr_en,
    input  logic             serr_en,
    input  logic [1:0]       status_clr,
    output logic             par_out,
    output logic             par_oe,
    output logic             perr_n,
    output logic             serr_pull,
    output logic             sts_det_perr,
    output logic             sts_sig_serr
);
    logic     addr_phase;
    logic     data_done;
    logic     par_prev;
    par_sts_t sts;

    pci_par_front #(.AD_W(AD_W), .CBE_W(CBE_W)) u_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .ad         (ad),
        .cbe_n      (cbe_n),
        .frame_n    (frame_n),
        .irdy_n     (irdy_n),
        .trdy_n     (trdy_n),
        .addr_phase (addr_phase),
        .data_done  (data_done),
        .par_prev   (par_prev)
    );

    pci_par_drive u_drive (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_phase (addr_phase),
        .irdy_n     (irdy_n),
        .trdy_n     (trdy_n),
        .is_master  (is_master),
        .is_write   (is_write),
        .par_prev   (par_prev),
        .par_out    (par_out),
        .par_oe     (par_oe)
    );

    pci_par_check u_check (
        .clk           (clk),
        .rst_n         (rst_n),
        .addr_phase    (addr_phase),
        .data_done     (data_done),
        .is_master     (is_master),
        .is_write      (is_write),
        .special_cycle (special_cycle),
        .par_prev      (par_prev),
        .par_in        (par_in),
        .perr_en       (perr_en),
        .serr_en       (serr_en),
        .status_clr    (status_clr),
        .perr_n        (perr_n),
        .serr_pull     (serr_pull),
        .sts           (sts)
    );

    assign sts_det_perr = sts.det_perr;
    assign sts_sig_serr = sts.sig_serr;

    // Driven PAR makes last clock's AD, C/BE# and PAR even.
    assert_par_even_R1: assert property (@(posedge clk) disable iff (!rst_n)
        par_oe |-> (par_out == $past(^{ad, cbe_n})));

    // Reset leaves every report line quiet.
    assert_reset_quiet_R10: assert property (@(posedge clk)
        $past(!rst_n) |-> (!par_oe && perr_n && !serr_pull));
endmodule

// File: tb/pci_parity_unit_bench.sv
module pci_parity_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ad = '0;
    logic [3:0]  cbe_n = '0;
    logic        frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1;
    logic        par_in = 1'b0;
    logic        is_master = 1'b0, is_write = 1'b0, special_cycle = 1'b0;
    logic        perr_en = 1'b1, serr_en = 1'b1;
    logic [1:0]  status_clr = '0;
    logic        par_out, par_oe, perr_n, serr_pull, sts_det_perr, sts_sig_serr;

    int  errors = 0;
    int  checks = 0;
    bit  done = 0;
    logic prev_par = 1'b0;

    always #5 clk = ~clk;

    pci_parity_unit u_pci_parity_unit (
        .clk(clk), .rst_n(rst_n), .ad(ad), .cbe_n(cbe_n), .frame_n(frame_n),
        .irdy_n(irdy_n), .trdy_n(trdy_n), .par_in(par_in), .is_master(is_master),
        .is_write(is_write), .special_cycle(special_cycle), .perr_en(perr_en),
        .serr_en(serr_en), .status_clr(status_clr), .par_out(par_out),
        .par_oe(par_oe), .perr_n(perr_n), .serr_pull(serr_pull),
        .sts_det_perr(sts_det_perr), .sts_sig_serr(sts_sig_serr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One bus clock; the other agent's PAR follows its bits by one clock.
    task automatic cyc(input logic fr, input logic ir, input logic tr,
                       input logic [31:0] a, input logic [3:0] c, input logic bad);
        frame_n = fr; irdy_n = ir; trdy_n = tr; ad = a; cbe_n = c;
        par_in = prev_par ^ bad;
        prev_par = ^{a, c};
        @(negedge clk);
    endtask

    task automatic idle(input logic bad);
        cyc(1'b1, 1'b1, 1'b1, 32'h0, 4'hF, bad);
    endtask

    task automatic t_reset;
        chk("R10 par_oe", par_oe, 0);
        chk("R10 perr_n", perr_n, 1);
        chk("R10 serr_pull", serr_pull, 0);
        chk("R10 status", {sts_det_perr, sts_sig_serr}, 0);
    endtask

    task automatic t_master_write;
        is_master = 1; is_write = 1; idle(0);
        cyc(0, 1, 1, 32'h1234_5678, 4'h7, 0);
        chk("R2 addr oe", par_oe, 1);
        chk("R1 addr par", par_out, ^{32'h1234_5678, 4'h7});
        cyc(1, 0, 1, 32'hA5A5_0F0F, 4'h2, 0);
        chk("R3 wait oe", par_oe, 1);
        chk("R1 wait par", par_out, ^{32'hA5A5_0F0F, 4'h2});
        cyc(1, 0, 0, 32'h8000_0001, 4'h0, 0);
        chk("R3 hold oe", par_oe, 1);
        chk("R1 data par", par_out, ^{32'h8000_0001, 4'h0});
        idle(0);
        chk("R3 release oe", par_oe, 0);
    endtask

    task automatic t_target_read;
        is_master = 0; is_write = 0; idle(0);
        cyc(0, 1, 1, 32'h0000_4000, 4'h6, 0);
        chk("R4 target addr quiet", par_oe, 0);
        cyc(1, 0, 0, 32'hDEAD_BEEF, 4'h3, 0);
        chk("R4 target read oe", par_oe, 1);
        chk("R1 target read par", par_out, ^{32'hDEAD_BEEF, 4'h3});
        idle(0);
        chk("R4 target read release", par_oe, 0);
        chk("R7 good addr no serr", serr_pull, 0);
    endtask

    task automatic t_target_write;
        is_master = 0; is_write = 1; idle(0);
        cyc(0, 1, 1, 32'h0000_4000, 4'h7, 0);
        cyc(1, 0, 0, 32'h1111_0000, 4'h0, 0);
        chk("R4 target write quiet", par_oe, 0);
        idle(0);
        chk("R5 good data no perr", perr_n, 1);
        chk("R8 good data no status", sts_det_perr, 0);
        idle(0);
        cyc(0, 1, 1, 32'h0000_4004, 4'h7, 0);
        cyc(1, 0, 0, 32'h0F0F_00FF, 4'h1, 0);
        idle(1);
        chk("R5 target write perr low", perr_n, 0);
        chk("R8 data error status", sts_det_perr, 1);
        idle(0);
        chk("R5 perr one clock", perr_n, 1);
        chk("R9 status sticky", sts_det_perr, 1);
        status_clr = 2'b10; idle(0); status_clr = 2'b00;
        chk("R9 clear bit 15", sts_det_perr, 0);
    endtask

    task automatic t_master_read;
        is_master = 1; is_write = 0; idle(0);
        cyc(0, 1, 1, 32'h0000_8000, 4'h6, 0);
        cyc(1, 0, 0, 32'h7777_7777, 4'h0, 0);
        chk("R4 master read quiet", par_oe, 0);
        idle(1);
        chk("R5 master read perr low", perr_n, 0);
        idle(0);
        chk("R5 master read perr release", perr_n, 1);
        status_clr = 2'b10; idle(0); status_clr = 2'b00;
    endtask

    task automatic t_special_and_disabled;
        is_master = 0; is_write = 1; special_cycle = 1; idle(0);
        cyc(0, 1, 1, 32'h0, 4'h1, 0);
        cyc(1, 0, 0, 32'h0000_0003, 4'h0, 0);
        idle(1);
        chk("R6 special no perr", perr_n, 1);
        chk("R8 special still detected", sts_det_perr, 1);
        special_cycle = 0;
        status_clr = 2'b10; idle(0); status_clr = 2'b00;
        perr_en = 0;
        cyc(0, 1, 1, 32'h0000_4000, 4'h7, 0);
        cyc(1, 0, 0, 32'h0000_0005, 4'h0, 0);
        idle(1);
        chk("R5 disabled no perr", perr_n, 1);
        chk("R8 disabled still detected", sts_det_perr, 1);
        perr_en = 1;
        status_clr = 2'b10; idle(0); status_clr = 2'b00;
    endtask

    task automatic t_addr_error;
        is_master = 0; is_write = 1; serr_en = 1; idle(0);
        cyc(0, 1, 1, 32'h0000_4000, 4'h7, 0);
        idle(1);
        chk("R7 serr pulled", serr_pull, 1);
        chk("R7 bit 14 set", sts_sig_serr, 1);
        chk("R8 addr error bit 15", sts_det_perr, 1);
        idle(0);
        chk("R7 serr one clock", serr_pull, 0);
        status_clr = 2'b11; idle(0); status_clr = 2'b00;
        chk("R9 clear both", {sts_det_perr, sts_sig_serr}, 0);
        cyc(0, 1, 1, 32'h0000_4000, 4'h7, 0);
        status_clr = 2'b11; idle(1); status_clr = 2'b00;
        chk("R9 set beats clear", {sts_det_perr, sts_sig_serr}, 2'b11);
        status_clr = 2'b11; idle(0); status_clr = 2'b00;
        serr_en = 0;
        cyc(0, 1, 1, 32'h0000_4000, 4'h7, 0);
        idle(1);
        chk("R7 disabled no serr", serr_pull, 0);
        chk("R7 disabled no bit 14", sts_sig_serr, 0);
        chk("R8 disabled bit 15", sts_det_perr, 1);
        serr_en = 1;
        status_clr = 2'b10; idle(0); status_clr = 2'b00;
        is_master = 1;
        cyc(0, 1, 1, 32'h0000_4000, 4'h7, 0);
        idle(1);
        chk("R7 master no address check", {serr_pull, sts_det_perr}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_master_write();
        t_target_read();
        t_target_write();
        t_master_read();
        t_special_and_disabled();
        t_addr_error();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule